// File: doc/BRIEF.md
# Regulator Startup Sequencer

This block is the control state machine that takes a voltage regulator out of shutdown. It watches three enable qualifiers that have already been digitized: bias supply good, power-enable request, and the thermal/enable pin above its threshold. While any qualifier is low, the block holds the PWM drivers tri-stated.

Once all three qualifiers are high, the block asks for a soft-start ramp and waits for the ramp to report completion. It then waits for the output to sit inside its regulation window before it raises ready. If a qualifier drops at any point, the block returns to shutdown.

A thermal indication can already be present before startup. It sets a sticky alert, which appears both as an active-low alert pin and as a status bit. Only an explicit fault-clear command, with its own command code, releases the alert.

Top module: `vr_startup_seq`

## Requirements
- R1: While reset is asserted, the outputs are: pwm_oe low, ss_req low, ready low, alert_n high and status_therm low.
- R2: The block leaves shutdown only when bias_good, pwr_en and therm_en_ok are all high in the same cycle. If any one of them is low, the outputs stay in the shutdown state.
- R3: In shutdown, pwm_oe is low, so the drivers are tri-stated. In shutdown, ss_req and ready are also low.
- R4: From shutdown, all three qualifiers high enters soft-start one cycle later. In soft-start, pwm_oe is high, ss_req is high and ready is low.
- R5: In soft-start, vout_in_win has no effect. An ss_done pulse leaves soft-start for the window wait one cycle later. In the window wait, ss_req and ready are both low.
- R6: In the window wait, ready rises one cycle after vout_in_win is seen high. Until then, ready stays low.
- R7: Any qualifier going low in soft-start, window wait or run returns the block to shutdown one cycle later. This drops pwm_oe, ss_req and ready.
- R8: A high therm_alert in any state makes alert_n low and status_therm high one cycle later. The alert holds until it is cleared.
- R9: When cmd_valid is high with cmd_code equal to 8'h03, the alert clears one cycle later: alert_n goes high and status_therm goes low.
- R10: Any other cmd_code, or cmd_code 8'h03 with cmd_valid low, leaves alert_n and status_therm unchanged.
- R11: When a clear command and therm_alert arrive in the same cycle, the alert stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bias_good | input | 1 | Bias supply past its power-on-reset level |
| pwr_en | input | 1 | Power-enable comparator output |
| therm_en_ok | input | 1 | Thermal/enable pin above its enable threshold |
| therm_alert | input | 1 | Thermal alert indication |
| ss_done | input | 1 | Soft-start ramp finished |
| vout_in_win | input | 1 | Output voltage inside the regulation window |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| pwm_oe | output | 1 | PWM output enable; low means tri-state |
| ss_req | output | 1 | Soft-start request |
| ready | output | 1 | Regulator ready |
| alert_n | output | 1 | Active-low alert |
| status_therm | output | 1 | Thermal status bit |

## Verification
Every result is due exactly one clock edge after the input that causes it. This holds for state changes and for alert set and clear, because both the state and the alert sit in a single register stage; the reset values are the only exception and appear immediately.

The driver applies each stimulus on a falling edge and queues the outputs that should follow. The monitor pops one entry one nanosecond after each rising edge, so every comparison lands in the cycle where the result becomes visible. The reset values are checked directly while reset is held.

// File: rtl/vr_startup_seq.sv
module vr_startup_seq #(
  parameter int          CMD_W    = 8,
  parameter logic [7:0]  CLR_CODE = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bias_good,
  input  logic             pwr_en,
  input  logic             therm_en_ok,
  input  logic             therm_alert,
  input  logic             ss_done,
  input  logic             vout_in_win,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             pwm_oe,
  output logic             ss_req,
  output logic             ready,
  output logic             alert_n,
  output logic             status_therm
);

  typedef enum logic [1:0] {SHUTDOWN, SOFTSTART, WAIT_WINDOW, RUN} st_t;

  st_t  st_q, st_d;
  logic alert_q;

  wire en_all = bias_good & pwr_en & therm_en_ok;
  wire clr    = cmd_valid & (cmd_code == CMD_W'(CLR_CODE));

  always_comb begin
    st_d = st_q;
    if (!en_all) st_d = SHUTDOWN;
    else begin
      case (st_q)
        SHUTDOWN:    st_d = SOFTSTART;
        SOFTSTART:   if (ss_done)     st_d = WAIT_WINDOW;
        WAIT_WINDOW: if (vout_in_win) st_d = RUN;
        default:     st_d = RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SHUTDOWN;
      alert_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (therm_alert)  alert_q <= 1'b1;
      else if (clr)     alert_q <= 1'b0;
    end
  end

  assign pwm_oe       = (st_q != SHUTDOWN);
  assign ss_req       = (st_q == SOFTSTART);
  assign ready        = (st_q == RUN);
  assign alert_n      = ~alert_q;
  assign status_therm = alert_q;

endmodule

// File: rtl/vr_startup_seq_chk.sv
module vr_startup_seq_chk #(
  parameter int          CMD_W    = 8,
  parameter logic [7:0]  CLR_CODE = 8'h03
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bias_good,
  input logic             pwr_en,
  input logic             therm_en_ok,
  input logic             therm_alert,
  input logic             ss_done,
  input logic             vout_in_win,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic             pwm_oe,
  input logic             ss_req,
  input logic             ready,
  input logic             alert_n,
  input logic             status_therm
);
  wire en_all = bias_good & pwr_en & therm_en_ok;
  wire clr    = cmd_valid & (cmd_code == CMD_W'(CLR_CODE));

  a_r2_needs_all_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |=> (!pwm_oe && !ss_req && !ready));

  a_r3_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe |-> (!ss_req && !ready));

  a_r4_enter_softstart: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_oe && en_all) |=> (pwm_oe && ss_req && !ready));

  a_r5_leave_softstart: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_req && ss_done && en_all) |=> (pwm_oe && !ss_req && !ready));

  a_r6_ready_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe && !ss_req && !ready && vout_in_win && en_all) |=> ready);

  a_r8_alert_sets: assert property (@(posedge clk) disable iff (!rst_n)
    therm_alert |=> (!alert_n && status_therm));

  a_r9_alert_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_alert && clr) |=> (alert_n && !status_therm));

  a_r10_alert_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_alert && !clr) |=> $stable(status_therm));
endmodule

bind vr_startup_seq vr_startup_seq_chk #(.CMD_W(CMD_W), .CLR_CODE(CLR_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bias_good(bias_good), .pwr_en(pwr_en),
  .therm_en_ok(therm_en_ok), .therm_alert(therm_alert), .ss_done(ss_done),
  .vout_in_win(vout_in_win), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .pwm_oe(pwm_oe), .ss_req(ss_req), .ready(ready), .alert_n(alert_n),
  .status_therm(status_therm));

// File: tb/vr_startup_seq_tb.sv
`timescale 1ns/1ps
module vr_startup_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_good = 0, pwr_en = 0, therm_en_ok = 0, therm_alert = 0;
  logic ss_done = 0, vout_in_win = 0, cmd_valid = 0;
  logic [7:0] cmd_code = 8'h00;
  logic pwm_oe, ss_req, ready, alert_n, status_therm;

  int n_run = 0, n_fail = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  vr_startup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bias_good(bias_good), .pwr_en(pwr_en),
    .therm_en_ok(therm_en_ok), .therm_alert(therm_alert), .ss_done(ss_done),
    .vout_in_win(vout_in_win), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pwm_oe(pwm_oe), .ss_req(ss_req), .ready(ready), .alert_n(alert_n),
    .status_therm(status_therm));

  function automatic logic [4:0] outs();
    return {pwm_oe, ss_req, ready, alert_n, status_therm};
  endfunction

  task automatic compare(input logic [4:0] exp, input string tag);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got {oe,ss,rdy,alert_n,stat}=%b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic step(input logic [2:0] en, input logic alrt, input logic ssd,
                      input logic win, input logic cv, input logic [7:0] code,
                      input logic [4:0] exp, input string tag);
    @(negedge clk);
    {bias_good, pwr_en, therm_en_ok} = en;
    therm_alert = alrt; ss_done = ssd; vout_in_win = win;
    cmd_valid = cv; cmd_code = code;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(5'b00010, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    // {pwm_oe, ss_req, ready, alert_n, status_therm}
    step(3'b000, 0,0,0,0,8'h00, 5'b00010, "R2 no enables");
    step(3'b110, 0,0,0,0,8'h00, 5'b00010, "R2 thermal enable missing");
    step(3'b101, 0,0,0,0,8'h00, 5'b00010, "R2 power enable missing");
    step(3'b011, 0,0,0,0,8'h00, 5'b00010, "R3 bias missing, tri-stated");
    step(3'b111, 0,0,1,0,8'h00, 5'b11010, "R4 enter soft-start");
    step(3'b111, 0,0,1,0,8'h00, 5'b11010, "R5 window ignored in soft-start");
    step(3'b111, 0,1,0,0,8'h00, 5'b10010, "R5 ss_done to window wait");
    step(3'b111, 0,0,0,0,8'h00, 5'b10010, "R6 no ready outside window");
    step(3'b111, 0,0,1,0,8'h00, 5'b10110, "R6 ready in window");
    step(3'b111, 0,0,1,0,8'h00, 5'b10110, "R6 run holds");
    step(3'b110, 0,0,1,0,8'h00, 5'b00010, "R7 lose thermal enable in run");
    step(3'b111, 0,0,0,0,8'h00, 5'b11010, "R4 restart");
    step(3'b101, 0,0,0,0,8'h00, 5'b00010, "R7 lose power enable in soft-start");
    step(3'b111, 0,0,0,0,8'h00, 5'b11010, "R4 restart again");
    step(3'b111, 0,1,0,0,8'h00, 5'b10010, "R5 to window wait");
    step(3'b011, 0,0,0,0,8'h00, 5'b00010, "R7 lose bias in window wait");
    step(3'b000, 1,0,0,0,8'h00, 5'b00001, "R8 alert before startup");
    step(3'b000, 0,0,0,1,8'h04, 5'b00001, "R10 wrong code ignored");
    step(3'b000, 0,0,0,0,8'h03, 5'b00001, "R10 code without strobe ignored");
    step(3'b000, 1,0,0,1,8'h03, 5'b00001, "R11 set wins over clear");
    step(3'b000, 0,0,0,1,8'h03, 5'b00010, "R9 clear command");
    step(3'b000, 0,0,0,0,8'h00, 5'b00010, "R9 stays clear");
    step(3'b111, 0,0,0,0,8'h00, 5'b11010, "R4 startup");
    step(3'b111, 0,1,0,0,8'h00, 5'b10010, "R5 ramp done");
    step(3'b111, 0,0,1,0,8'h00, 5'b10110, "R6 run");
    step(3'b111, 1,0,1,0,8'h00, 5'b10101, "R8 alert in run");
    step(3'b111, 0,0,1,1,8'h03, 5'b10110, "R9 clear in run");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule